// File: doc/BRIEF.md
# Dual-Counter Conversion Control Unit

This block controls an A/D measurement that works by counting RC-oscillator cycles. A single 4-bit control register on a simple synchronous bus holds three fields. The first selects the internal supply: the regulator, or the settled supply the oscillator needs. The second chooses which of two counters, A or B, raises the end-of-conversion interrupt. The third is a run bit. The run bit starts the oscillator and both counters, and it also acts as a busy flag. Hardware clears it on the first overflow from either counter.

The oscillator may not start until the internal supply has settled. When the supply bit goes from 0 to 1, a settle down-counter is loaded, and it steps on an external tick. A start request made during the settle wait is held pending. The request takes effect once the wait has expired. Clearing the supply bit stops any conversion at once. The analog oscillator and the counter datapaths are outside this block; only their overflow pulses come in.

Top module: `conv_ctl_top`

## Requirements
- R1: After reset the register reads 0 and the oscillator enable, counter run and interrupt outputs are all low.
- R2: The register sits at address `REG_ADDR`. Bit 2 is the supply select, bit 1 is the interrupt source (0 = counter A, 1 = counter B) and bit 0 is the run bit. Bit 3 always reads 0. A write takes effect on the clock edge that samples the strobe. A read returns the register combinationally. Writes to other addresses change nothing, and reads at other addresses return 0.
- R3: While running, an overflow of the selected counter produces an interrupt pulse in the cycle after the edge that samples the overflow.
- R4: While running, an overflow of either counter clears the run bit and stops the oscillator at that edge. An overflow of the counter that is not selected raises no interrupt.
- R5: While the supply bit is 0, a start request has no effect, the oscillator stays off and overflows raise no interrupt.
- R6: A 0-to-1 change of the supply bit starts a wait of `SETTLE_TICKS` ticks. A start request made during the wait reads back as 1 in bit 0 while the oscillator stays off. The oscillator starts on the clock edge after the tick that empties the wait.
- R7: The interrupt is a single-cycle pulse.
- R8: When a write of the run bit and an overflow fall in the same cycle, the overflow clear wins.
- R9: Writing the supply bit to 0 while a conversion runs clears the run bit and stops the oscillator at that same edge.
- R10: Writing 0 to the run bit stops a running conversion at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 4 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 4 | Read data, combinational |
| ovf_a_i | input | 1 | Counter A overflow pulse |
| ovf_b_i | input | 1 | Counter B overflow pulse |
| tick_i | input | 1 | Settle-timer tick |
| osc_en_o | output | 1 | RC oscillator enable |
| cnt_run_o | output | 1 | Counter A/B run enable |
| irq_o | output | 1 | Conversion interrupt pulse |

## Verification
The hardest state to reach is the promotion of a pending start at the exact end of the settle wait. The bench writes the supply and run bits together, then steps the tick input one pulse at a time. It samples the oscillator enable at the tick that empties the wait, where the enable must still be low, and again one cycle later, where it must be high. The second hard case is the collision of a bus write with an overflow in one cycle. The bench drives the strobe and the overflow on the same falling edge, so the rising edge samples both together.

// File: rtl/conv_ctl_pkg.sv
package conv_ctl_pkg;
  localparam int unsigned REG_W   = 4;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_SEL = 1;
  localparam int unsigned BIT_SUP = 2;

  typedef struct packed {
    logic sup;
    logic sel;
    logic en;
  } ctl_t;
endpackage

// File: rtl/conv_ctl_settle.sv
module conv_ctl_settle #(
  parameter int unsigned SETTLE_TICKS = 6,
  localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic sup_i,
  input  logic tick_i,
  output logic ready_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= CNT_W'(SETTLE_TICKS);
    else if (!sup_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign ready_o = sup_i && (cnt_q == '0);

  // R6: once loaded the wait holds the full length on the next cycle
  p_settle_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ready_o);
endmodule

// File: rtl/conv_ctl_core.sv
module conv_ctl_core
  import conv_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ovf_a_i,
  input  logic             ovf_b_i,
  input  logic             ready_i,
  output logic             load_o,
  output ctl_t             ctl_o,
  output logic             pend_o,
  output logic             irq_o
);
  ctl_t ctl_q, ctl_d;
  logic pend_q, pend_d;
  logic irq_q, irq_d;
  logic ovf_any;
  logic unused_wbit;

  assign unused_wbit = wdata_i[REG_W-1];
  assign ovf_any = ovf_a_i | ovf_b_i;
  assign load_o  = wr_i && wdata_i[BIT_SUP] && !ctl_q.sup;

  always_comb begin
    ctl_d.sup = wr_i ? wdata_i[BIT_SUP] : ctl_q.sup;
    ctl_d.sel = wr_i ? wdata_i[BIT_SEL] : ctl_q.sel;
    ctl_d.en  = ctl_q.en;
    pend_d    = pend_q;
    if (!ctl_d.sup) begin
      ctl_d.en = 1'b0;
      pend_d   = 1'b0;
    end else if ((ctl_q.en || pend_q) && ovf_any) begin
      // hardware clear wins over a same-cycle write
      ctl_d.en = 1'b0;
      pend_d   = 1'b0;
    end else if (wr_i) begin
      if (wdata_i[BIT_EN]) begin
        ctl_d.en = ready_i;
        pend_d   = !ready_i;
      end else begin
        ctl_d.en = 1'b0;
        pend_d   = 1'b0;
      end
    end else if (pend_q && ready_i) begin
      ctl_d.en = 1'b1;
      pend_d   = 1'b0;
    end
    irq_d = ctl_q.en && (ctl_q.sel ? ovf_b_i : ovf_a_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign ctl_o  = ctl_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R3
  p_irq_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(ctl_q.en));
  // R4
  p_ovf_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.en && ovf_any) |=> !ctl_q.en);
  // R5
  p_supply_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.en |-> ctl_q.sup);
  // R6
  p_settle_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.en) |-> $past(ready_i));
  // R7
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R9
  p_supply_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[BIT_SUP]) |=> !ctl_q.en);
endmodule

// File: rtl/conv_ctl_top.sv
module conv_ctl_top
  import conv_ctl_pkg::*;
#(
  parameter int unsigned        ADDR_W       = 4,
  parameter logic [ADDR_W-1:0]  REG_ADDR     = 'hA,
  parameter int unsigned        SETTLE_TICKS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  input  logic              bus_we_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              ovf_a_i,
  input  logic              ovf_b_i,
  input  logic              tick_i,
  output logic              osc_en_o,
  output logic              cnt_run_o,
  output logic              irq_o
);
  logic hit, wr, load, ready, pend;
  ctl_t ctl;

  assign hit = (bus_addr_i == REG_ADDR);
  assign wr  = bus_we_i && hit;

  conv_ctl_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .wdata_i (bus_wdata_i),
    .ovf_a_i (ovf_a_i),
    .ovf_b_i (ovf_b_i),
    .ready_i (ready),
    .load_o  (load),
    .ctl_o   (ctl),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );

  conv_ctl_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .sup_i   (ctl.sup),
    .tick_i  (tick_i),
    .ready_o (ready)
  );

  assign bus_rdata_o = hit ? {1'b0, ctl.sup, ctl.sel, ctl.en | pend} : '0;
  assign osc_en_o    = ctl.en;
  assign cnt_run_o   = ctl.en;

  // R2: bit 3 is never set
  p_rd_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rdata_o[REG_W-1]);
endmodule

// File: tb/conv_ctl_top_tb_top.sv
module conv_ctl_top_tb_top;
  localparam int CLK_P = 10;
  localparam logic [3:0] RA = 4'hA;
  localparam int ST = 6;

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = RA, wdata = 0, rdata;
  logic we = 0, ova = 0, ovb = 0, tick = 0;
  logic osc, run, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  conv_ctl_top #(.ADDR_W(4), .REG_ADDR(RA), .SETTLE_TICKS(ST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .ovf_a_i(ova), .ovf_b_i(ovb),
    .tick_i(tick), .osc_en_o(osc), .cnt_run_o(run), .irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic wr(input logic [3:0] d);
    addr = RA; we = 1; wdata = d; cyc(); we = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); tick = 0; end
  endtask
  task automatic ovf(input logic a, input logic b);
    ova = a; ovb = b; cyc(); ova = 0; ovb = 0;
  endtask
  task automatic rd(output logic [3:0] v);
    addr = RA; #1 v = rdata;
  endtask

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(v);
    chk("R1 rdata", v, 0); chk("R1 osc", osc, 0); chk("R1 run", run, 0); chk("R1 irq", irq, 0);

    // register sweep, no ticks so settle never expires
    for (int k = 0; k < 16; k++) begin
      wr(4'(k));
      rd(v);
      chk("R2 readback", v, ((k >> 2) & 1) * 4 + ((k >> 1) & 1) * 2 + (((k >> 2) & k) & 1));
      chk("R6 osc off during wait", osc, 0);
    end
    wr(0);
    addr = RA + 1; we = 1; wdata = 4'h7; cyc(); we = 0;
    rd(v); chk("R2 other addr write", v, 0);
    addr = RA + 1; #1 chk("R2 other addr read", rdata, 0);

    // supply off blocks start
    wr(4'h1); ticks(ST + 2);
    rd(v); chk("R5 start blocked", v, 0); chk("R5 osc", osc, 0);
    ovf(1, 1); chk("R5 no irq", irq, 0);

    // source x overflow sweep
    for (int sel = 0; sel < 2; sel++)
      for (int w = 0; w < 3; w++) begin
        wr(0);
        wr(4'(5 | (sel << 1)));
        rd(v); chk("R6 pending reads 1", v & 1, 1); chk("R6 osc pending", osc, 0);
        ticks(ST - 1); chk("R6 osc before expiry", osc, 0);
        ticks(1); chk("R6 osc at expiry tick", osc, 0);
        cyc(); chk("R6 osc started", osc, 1); chk("R6 run started", run, 1);
        ovf(w != 1, w != 0);
        chk("R3 irq source", irq, (w == 2 || w == sel) ? 1 : 0);
        chk("R4 osc cleared", osc, 0);
        rd(v); chk("R4 busy cleared", v & 1, 0); chk("R2 sel kept", (v >> 1) & 1, sel);
        cyc(); chk("R7 irq one cycle", irq, 0);
      end

    // collision: write start with overflow, supply settled, sel A
    wr(4'h5); chk("R10 immediate start", osc, 1);
    addr = RA; we = 1; wdata = 4'h5; ova = 1; cyc(); we = 0; ova = 0;
    chk("R8 osc cleared", osc, 0); chk("R8 irq", irq, 1);
    rd(v); chk("R8 readback", v, 4);

    // supply drop during run
    wr(4'h5); chk("R9 running", osc, 1);
    wr(4'h1); chk("R9 osc stopped", osc, 0);
    rd(v); chk("R9 readback", v, 0);

    // software stop
    wr(4'h4); ticks(ST); wr(4'h5); chk("R10 running", osc, 1);
    wr(4'h4); chk("R10 stopped", osc, 0); chk("R10 run", run, 0);
    rd(v); chk("R10 readback", v, 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule